// File: doc/BRIEF.md
# Flash Software Operation Error Checker

This block sits between the software command registers of a flash controller and the array sequencer. When software fires a start strobe with an operation code, program type, word count and start address, the checker decides within the same cycle whether the command is legal. A legal command is handed to the array through a one-cycle issue pulse. The block then counts word acknowledgements until the operation ends. An illegal command never reaches the array: it ends at once with a done flag and an error flag.

Every fault class has its own bit in a sticky error code. The classes are undefined operation, permission denial, uncorrectable read, program failure, program window overrun, unavailable program type and shadow update fault. Software clears a bit by writing 1 to it. The block also sets how many times the read FIFO may be popped after a read is accepted. Any pop beyond that limit, or any pop when no read was accepted, gets a bus error response. Such a pop does not stall anything.

Top module: `flash_op_guard`

## Requirements
- R1: An operation code of 3 (0 read, 1 program, 2 erase) at an accepted start edge sets error bit 0 and gives no issue pulse. The cycle after the start edge shows done_o=1 and err_o=1.
- R2: For a program, the sum of the address byte offset within a 64-byte window (addr_i[5:0]) and 4*(num_i+1) is checked. A sum above 64 sets error bit 4 and rejects the command. A sum of exactly 64 is accepted.
- R3: A program whose prog_type_i selects a type with type_avail_i[prog_type_i]=0 sets error bit 5 and is rejected.
- R4: mp_deny_i high at the start edge of any defined operation sets error bit 1 and rejects the command.
- R5: During a read, an ack_i beat with rd_uncorr_i high sets error bit 2. The read still runs to its last beat and ends with done_o=1 and err_o=1.
- R6: During a program, an ack_i beat with prog_fail_i high sets error bit 3. The program ends with done_o=1 and err_o=1.
- R7: shadow_fault_i sets error bit 6 in any state and does not change done_o, err_o or busy_o.
- R8: Error bits stay set until a 1 is written to err_clr_i at that bit. If a set and a clear of the same bit meet in one cycle, the set wins. Clearing one bit leaves the other bits unchanged.
- R9: An accepted start gives issue_o high for exactly the one cycle after the start edge. busy_o then stays high until num_i+1 ack_i beats arrive, or 1 beat for an erase. The operation ends with done_o=1 and err_o=0 when no fault occurred, and busy_o and done_o are never high together.
- R10: A start strobe while busy_o is high is ignored: no error bit, no issue pulse, and no change to the beat count of the running operation.
- R11: An accepted read allows num_i+1 FIFO pops. A pop with no allowance left, including a pop after reset or after a non-read start, gives bus_err_o=1 for one cycle after the pop edge. A later accepted read restores the allowance.
- R12: After reset, err_code_o, done_o, err_o, busy_o, issue_o and bus_err_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe from software |
| op_i | input | 2 | Operation code: 0 read, 1 program, 2 erase, 3 undefined |
| prog_type_i | input | TYPE_W | Selected program type |
| num_i | input | NUM_W | Word count minus one |
| addr_i | input | ADDR_W | Start byte address |
| type_avail_i | input | TYPES | Per-type availability |
| mp_deny_i | input | 1 | Permission verdict: 1 means denied |
| ack_i | input | 1 | One word beat (or an erase) completed by the array |
| rd_uncorr_i | input | 1 | Current read beat is uncorrectable |
| prog_fail_i | input | 1 | Current program beat failed |
| shadow_fault_i | input | 1 | Shadow register update fault |
| fifo_pop_i | input | 1 | Software pops the read FIFO |
| err_clr_i | input | 7 | Write-1-to-clear mask for err_code_o |
| issue_o | output | 1 | Accepted command forwarded to the array |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Last operation ended |
| err_o | output | 1 | Last operation ended with an error |
| err_code_o | output | 7 | Sticky error classes: 0 op, 1 perm, 2 read, 3 prog, 4 window, 5 type, 6 update |
| bus_err_o | output | 1 | Bus error response for an illegal FIFO pop |

## Verification
Reads, programs and erases are run with several word counts, so each beat counter is checked against its own end point. Erase runs with a large num_i to show that it still ends after one beat. Window checks use spans of exactly 64 bytes at offsets 0 and 60 and spans of 65 or more. This separates the strict greater-than compare from a greater-or-equal compare, and shows that the offset term counts. FIFO pops are tried before any read, at the allowance, one past it, and after a fresh read. Faults injected during operations, start strobes fired while busy, and same-cycle set and clear of one bit check that the sticky code stays consistent.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_BAD   = 2'd3
  } fop_e;

  localparam int unsigned ERR_W  = 7;
  localparam int unsigned E_OP   = 0;
  localparam int unsigned E_MP   = 1;
  localparam int unsigned E_RD   = 2;
  localparam int unsigned E_PROG = 3;
  localparam int unsigned E_WIN  = 4;
  localparam int unsigned E_TYPE = 5;
  localparam int unsigned E_UPD  = 6;
endpackage

// File: rtl/flash_op_decode.sv
module flash_op_decode
  import flash_guard_pkg::*;
#(
  parameter int unsigned NUM_W      = 12,
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned WIN_BYTES  = 64,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned TYPES      = 2,
  localparam int unsigned TYPE_W    = (TYPES > 1) ? $clog2(TYPES) : 1
) (
  input  logic [1:0]        op_i,
  input  logic [TYPE_W-1:0] prog_type_i,
  input  logic [NUM_W-1:0]  num_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TYPES-1:0]  type_avail_i,
  input  logic              mp_deny_i,
  output logic [ERR_W-1:0]  start_err_o
);
  localparam int unsigned OFF_W  = $clog2(WIN_BYTES);
  localparam int unsigned SPAN_W = NUM_W + $clog2(WORD_BYTES) + OFF_W + 2;

  fop_e              op;
  logic [OFF_W-1:0]  offset;
  logic [SPAN_W-1:0] span;
  logic              type_ok;
  logic              is_prog;

  assign op      = fop_e'(op_i);
  assign is_prog = (op == OP_PROG);
  assign offset  = addr_i[OFF_W-1:0];
  // bytes touched, measured from the window base
  assign span = SPAN_W'(offset) + (SPAN_W'(num_i) + SPAN_W'(1)) * SPAN_W'(WORD_BYTES);

  if (TYPES > 1) begin : g_multi_type
    assign type_ok = (32'(prog_type_i) < TYPES) && type_avail_i[prog_type_i];
  end else begin : g_single_type
    logic unused_type;
    assign unused_type = ^prog_type_i;
    assign type_ok     = type_avail_i[0];
  end

  always_comb begin
    start_err_o         = '0;
    start_err_o[E_OP]   = (op == OP_BAD);
    start_err_o[E_MP]   = (op != OP_BAD) && mp_deny_i;
    start_err_o[E_WIN]  = is_prog && (span > SPAN_W'(WIN_BYTES));
    start_err_o[E_TYPE] = is_prog && !type_ok;
  end
endmodule

// File: rtl/flash_op_tracker.sv
module flash_op_tracker
  import flash_guard_pkg::*;
#(
  parameter int unsigned NUM_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             reject_i,
  input  logic [1:0]       op_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic             ack_i,
  input  logic             rd_uncorr_i,
  input  logic             prog_fail_i,
  output logic             busy_o,
  output logic             issue_o,
  output logic             done_o,
  output logic             err_o,
  output logic [ERR_W-1:0] run_err_o
);
  fop_e             cur_op;
  logic [NUM_W-1:0] beats_left;
  logic             op_fault;
  logic             beat;
  logic             last_beat;
  logic             fault_now;

  assign beat      = busy_o && ack_i;
  assign last_beat = (beats_left == '0);

  always_comb begin
    run_err_o         = '0;
    run_err_o[E_RD]   = beat && (cur_op == OP_READ) && rd_uncorr_i;
    run_err_o[E_PROG] = beat && (cur_op == OP_PROG) && prog_fail_i;
  end
  assign fault_now = |run_err_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      issue_o    <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      cur_op     <= OP_READ;
      beats_left <= '0;
      op_fault   <= 1'b0;
    end else begin
      issue_o <= accept_i;
      if (accept_i) begin
        busy_o     <= 1'b1;
        done_o     <= 1'b0;
        err_o      <= 1'b0;
        op_fault   <= 1'b0;
        cur_op     <= fop_e'(op_i);
        beats_left <= (fop_e'(op_i) == OP_ERASE) ? '0 : num_i;
      end else if (reject_i) begin
        done_o <= 1'b1;
        err_o  <= 1'b1;
      end else if (beat) begin
        if (last_beat) begin
          busy_o   <= 1'b0;
          done_o   <= 1'b1;
          err_o    <= op_fault | fault_now;
          op_fault <= 1'b0;
        end else begin
          beats_left <= beats_left - 1'b1;
          op_fault   <= op_fault | fault_now;
        end
      end
    end
  end
endmodule

// File: rtl/flash_pop_limiter.sv
module flash_pop_limiter #(
  parameter int unsigned NUM_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             load_read_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic             pop_i,
  output logic             bus_err_o
);
  logic [NUM_W:0] credit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      credit    <= '0;
      bus_err_o <= 1'b0;
    end else begin
      bus_err_o <= 1'b0;
      if (load_i) begin
        credit <= load_read_i ? ((NUM_W+1)'(num_i) + 1'b1) : '0;
      end else if (pop_i) begin
        if (credit == '0) bus_err_o <= 1'b1;
        else              credit    <= credit - 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_err_latch.sv
module flash_err_latch #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[i] <= 1'b0;
      else         q_o[i] <= set_i[i] | (q_o[i] & ~clr_i[i]);
    end
  end
endmodule

// File: rtl/flash_op_guard.sv
module flash_op_guard
  import flash_guard_pkg::*;
#(
  parameter int unsigned NUM_W      = 12,
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned WIN_BYTES  = 64,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned TYPES      = 2,
  localparam int unsigned TYPE_W    = (TYPES > 1) ? $clog2(TYPES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [TYPE_W-1:0] prog_type_i,
  input  logic [NUM_W-1:0]  num_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TYPES-1:0]  type_avail_i,
  input  logic              mp_deny_i,
  input  logic              ack_i,
  input  logic              rd_uncorr_i,
  input  logic              prog_fail_i,
  input  logic              shadow_fault_i,
  input  logic              fifo_pop_i,
  input  logic [6:0]        err_clr_i,
  output logic              issue_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [6:0]        err_code_o,
  output logic              bus_err_o
);
  logic [ERR_W-1:0] start_err;
  logic [ERR_W-1:0] run_err;
  logic [ERR_W-1:0] err_set;
  logic             take;
  logic             accept;
  logic             reject;

  flash_op_decode #(
    .NUM_W(NUM_W), .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES),
    .WORD_BYTES(WORD_BYTES), .TYPES(TYPES)
  ) i_decode (
    .op_i        (op_i),
    .prog_type_i (prog_type_i),
    .num_i       (num_i),
    .addr_i      (addr_i),
    .type_avail_i(type_avail_i),
    .mp_deny_i   (mp_deny_i),
    .start_err_o (start_err)
  );

  assign take   = start_i && !busy_o;
  assign accept = take && (start_err == '0);
  assign reject = take && (start_err != '0);

  flash_op_tracker #(.NUM_W(NUM_W)) i_tracker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .reject_i   (reject),
    .op_i       (op_i),
    .num_i      (num_i),
    .ack_i      (ack_i),
    .rd_uncorr_i(rd_uncorr_i),
    .prog_fail_i(prog_fail_i),
    .busy_o     (busy_o),
    .issue_o    (issue_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .run_err_o  (run_err)
  );

  flash_pop_limiter #(.NUM_W(NUM_W)) i_pop (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (take),
    .load_read_i(accept && (fop_e'(op_i) == OP_READ)),
    .num_i      (num_i),
    .pop_i      (fifo_pop_i),
    .bus_err_o  (bus_err_o)
  );

  always_comb begin
    err_set        = (take ? start_err : '0) | run_err;
    err_set[E_UPD] = shadow_fault_i;
  end

  flash_err_latch #(.W(ERR_W)) i_err (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (err_set),
    .clr_i (err_clr_i),
    .q_o   (err_code_o)
  );
endmodule

// File: rtl/flash_op_guard_chk.sv
module flash_op_guard_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [1:0] op_i,
  input logic       shadow_fault_i,
  input logic       fifo_pop_i,
  input logic [6:0] err_clr_i,
  input logic       issue_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [6:0] err_code_o,
  input logic       bus_err_o
);
  // R1
  bad_op_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op_i == 2'd3) |=> (err_code_o[0] && !issue_o));

  // R7
  upd_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shadow_fault_i |=> err_code_o[6]);

  // R8
  sticky_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(err_code_o) & ~$past(err_clr_i) & ~err_code_o) == 7'd0));

  // R9
  issue_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> ($past(start_i) && !$past(busy_o) && busy_o));

  // R9
  done_busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));

  // R10
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> !issue_o);

  // R11
  bus_err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> $past(fifo_pop_i));
endmodule

bind flash_op_guard flash_op_guard_chk i_chk (.*);

// File: tb/test_flash_op_guard.sv
module test_flash_op_guard;
  localparam int NUM_W = 12;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [0:0]  prog_type_i = '0;
  logic [NUM_W-1:0] num_i = '0;
  logic [19:0] addr_i = '0;
  logic [1:0]  type_avail_i = 2'b11;
  logic        mp_deny_i = 1'b0;
  logic        ack_i = 1'b0;
  logic        rd_uncorr_i = 1'b0;
  logic        prog_fail_i = 1'b0;
  logic        shadow_fault_i = 1'b0;
  logic        fifo_pop_i = 1'b0;
  logic [6:0]  err_clr_i = '0;
  logic        issue_o, busy_o, done_o, err_o, bus_err_o;
  logic [6:0]  err_code_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  flash_op_guard i_flash_op_guard (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic start_op(logic [1:0] op, logic ty, int num, int addr);
    op_i = op; prog_type_i = ty; num_i = NUM_W'(num); addr_i = 20'(addr);
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
  endtask

  task automatic beats(int n);
    for (int i = 0; i < n; i++) begin
      ack_i = 1'b1;
      tick();
    end
    ack_i = 1'b0;
  endtask

  task automatic clear_all();
    err_clr_i = '1;
    tick();
    err_clr_i = '0;
  endtask

  task automatic pop(output logic be);
    fifo_pop_i = 1'b1;
    tick();
    fifo_pop_i = 1'b0;
    be = bus_err_o;
  endtask

  task automatic t_reset();
    logic be;
    chk("R12 err_code", err_code_o, 0);
    chk("R12 done", done_o, 0);
    chk("R12 busy", busy_o, 0);
    chk("R12 issue", issue_o, 0);
    pop(be);
    chk("R11 pop before any read", be, 1);
    tick();
    chk("R11 bus_err one cycle", bus_err_o, 0);
  endtask

  task automatic t_read_ok();
    logic be;
    start_op(2'd0, 1'b0, 2, 'h100);
    chk("R9 issue", issue_o, 1);
    chk("R9 busy", busy_o, 1);
    tick();
    chk("R9 issue one cycle", issue_o, 0);
    beats(2);
    chk("R9 busy mid", busy_o, 1);
    beats(1);
    chk("R9 busy end", busy_o, 0);
    chk("R9 done/err", {done_o, err_o}, 2'b10);
    for (int i = 0; i < 3; i++) begin
      pop(be);
      chk("R11 legal pop", be, 0);
    end
    pop(be);
    chk("R11 extra pop", be, 1);
    start_op(2'd0, 1'b0, 0, 0);
    beats(1);
    pop(be);
    chk("R11 no lockup after bus error", be, 0);
    chk("R9 err_code clean", err_code_o, 0);
  endtask

  task automatic t_bad_op();
    start_op(2'd3, 1'b0, 4, 0);
    chk("R1 op bit", err_code_o, 7'h01);
    chk("R1 no issue", {issue_o, busy_o}, 2'b00);
    chk("R1 done/err", {done_o, err_o}, 2'b11);
    err_clr_i = 7'h01;
    tick();
    err_clr_i = '0;
    chk("R8 w1c", err_code_o, 0);
  endtask

  task automatic t_window();
    logic be;
    start_op(2'd1, 1'b0, 15, 'h40);
    chk("R2 span 64 at offset 0", {issue_o, err_code_o[4]}, 2'b10);
    beats(15);
    chk("R9 prog busy before last", busy_o, 1);
    beats(1);
    chk("R9 prog done", {busy_o, done_o, err_o}, 3'b010);
    pop(be);
    chk("R11 pop after program", be, 1);
    start_op(2'd1, 1'b0, 15, 'h44);
    chk("R2 span 68", err_code_o, 7'h10);
    chk("R2 no issue", issue_o, 0);
    clear_all();
    start_op(2'd1, 1'b0, 0, 'h7C);
    chk("R2 offset 60 one word", {issue_o, err_code_o[4]}, 2'b10);
    beats(1);
    start_op(2'd1, 1'b0, 0, 'h7D);
    chk("R2 offset 61 one word", err_code_o, 7'h10);
    clear_all();
  endtask

  task automatic t_type();
    type_avail_i = 2'b01;
    start_op(2'd1, 1'b1, 0, 0);
    chk("R3 type bit", err_code_o, 7'h20);
    chk("R3 rejected", {issue_o, done_o, err_o}, 3'b011);
    clear_all();
    start_op(2'd1, 1'b0, 0, 0);
    chk("R3 available type", {issue_o, err_code_o[5]}, 2'b10);
    beats(1);
    type_avail_i = 2'b11;
  endtask

  task automatic t_mp();
    mp_deny_i = 1'b1;
    start_op(2'd2, 1'b0, 0, 0);
    mp_deny_i = 1'b0;
    chk("R4 mp bit", err_code_o, 7'h02);
    chk("R4 no issue", {issue_o, busy_o, err_o}, 3'b001);
    clear_all();
  endtask

  task automatic t_rd_err();
    start_op(2'd0, 1'b0, 1, 0);
    rd_uncorr_i = 1'b1;
    beats(1);
    rd_uncorr_i = 1'b0;
    chk("R5 rd bit", err_code_o, 7'h04);
    chk("R5 still busy", busy_o, 1);
    beats(1);
    chk("R5 done with error", {busy_o, done_o, err_o}, 3'b011);
    clear_all();
  endtask

  task automatic t_prog_err();
    start_op(2'd1, 1'b0, 0, 0);
    prog_fail_i = 1'b1;
    beats(1);
    prog_fail_i = 1'b0;
    chk("R6 prog bit", err_code_o, 7'h08);
    chk("R6 done with error", {busy_o, done_o, err_o}, 3'b011);
    clear_all();
  endtask

  task automatic t_shadow();
    start_op(2'd2, 1'b0, 9, 0);
    shadow_fault_i = 1'b1;
    tick();
    shadow_fault_i = 1'b0;
    chk("R7 bit while busy", err_code_o, 7'h40);
    chk("R7 busy kept", {busy_o, done_o}, 2'b10);
    beats(1);
    chk("R9 erase one beat", {busy_o, done_o, err_o}, 3'b010);
    shadow_fault_i = 1'b1;
    err_clr_i = 7'h40;
    tick();
    shadow_fault_i = 1'b0;
    err_clr_i = '0;
    chk("R8 set beats clear", err_code_o, 7'h40);
    chk("R7 done unchanged", {done_o, err_o}, 2'b10);
    start_op(2'd3, 1'b0, 0, 0);
    err_clr_i = 7'h40;
    tick();
    err_clr_i = '0;
    chk("R8 partial clear", err_code_o, 7'h01);
    clear_all();
  endtask

  task automatic t_busy_ignore();
    start_op(2'd0, 1'b0, 3, 0);
    beats(1);
    start_op(2'd3, 1'b0, 0, 0);
    chk("R10 no op bit", err_code_o, 0);
    chk("R10 no issue", issue_o, 0);
    start_op(2'd2, 1'b0, 0, 0);
    beats(2);
    chk("R10 count kept", busy_o, 1);
    beats(1);
    chk("R10 ends on own count", {busy_o, done_o, err_o}, 3'b010);
  endtask

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_read_ok();
    t_bad_op();
    t_window();
    t_type();
    t_mp();
    t_rd_err();
    t_prog_err();
    t_shadow();
    t_busy_ignore();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule